// File: doc/BRIEF.md
# Up-Counting Compare Timer Channel

A single timer channel meant to sit inside a memory-mapped system controller. It holds three word-wide registers: a control word, a compare value and a live counter. While its enable bit is set, the counter climbs by one per clock. When the counter has reached or passed the compare value, the channel sends one interrupt pulse. It then either starts a fresh period from zero or switches itself off, as the auto-restart bit selects.

The enclosing register bank drives a simple port. A write strobe, a register select and a data word update one register. A separate read select returns the current value of any register through a combinational multiplexer. Software can preload the counter, change the compare value in the middle of a period and freeze the count by clearing the enable bit. Register select codes: 0 control, 1 compare, 2 counter, 3 unused (reads zero, writes ignored).

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset, the control, compare and counter registers read zero, the timer is stopped and `irq_o` is low.
- R2: A control write stores data bit 0 as enable and data bit 1 as auto-restart. Control reads return them in bits 0 and 1, with all other bits zero.
- R3: While enable is set and the counter is below the compare value, the counter increases by one on every clock.
- R4: A terminal count is an edge where enable is set and counter >= compare. After that edge `irq_o` is high for exactly one cycle, unless the next edge is again a terminal count.
- R5: At a terminal count with auto-restart clear, hardware clears the enable bit and the counter holds its value.
- R6: At a terminal count with auto-restart set, the counter becomes zero on that edge and enable stays set.
- R7: A counter write loads the data word. It takes precedence over hardware updates in the same cycle, and counting resumes from the loaded value when enable is set.
- R8: While enable is clear, the counter keeps its value and no interrupt is raised.
- R9: A compare write is used from the next clock edge onward, including in the current period.
- R10: If the counter is already at or above the compare value when enable is set, the terminal count is taken on the next clock edge.
- R11: A control write in the same cycle as a terminal count sets the enable and auto-restart bits to the written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for the write |
| wr_data_i | input | CNT_W | Write data |
| rd_sel_i | input | 2 | Register selected for the read |
| rd_data_o | output | CNT_W | Read data (combinational) |
| irq_o | output | 1 | Interrupt pulse at terminal count |

## Verification
The bench builds the channel with an 8-bit counter. Random compare and preload values then span the whole range, including all ones and values already past the compare point, and terminal counts occur every few dozen cycles in the random phase. The narrow width also makes collisions frequent between software writes and terminal counts. These collisions settle the write-priority rules of R7 and R11.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_AR_BIT = 1;
endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  logic [1:0] wr_bits_i,
  input  logic       hit_i,
  output logic       en_o,
  output logic       ar_o
);
  logic en_q, ar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      ar_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      en_q <= wr_bits_i[CTRL_EN_BIT];
      ar_q <= wr_bits_i[CTRL_AR_BIT];
    end else if (hit_i && !ar_q) begin
      en_q <= 1'b0;  // one-shot: self-disable
    end
  end

  assign en_o = en_q;
  assign ar_o = ar_q;

  // R5
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !ar_q && !ctrl_wr_i) |=> !en_q);
  // R6
  restart_keeps_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ar_q && !ctrl_wr_i) |=> en_q);
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ar_i,
  input  logic             cmp_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_d;
  logic             hit;

  assign hit = en_i && (cnt_q >= cmp_q);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_i)        cnt_d = wr_data_i;
    else if (hit)        cnt_d = ar_i ? '0 : cnt_q;
    else if (en_i)       cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_wr_i) cmp_q <= wr_data_i;
    end
  end

  assign hit_o = hit;
  assign cmp_o = cmp_q;
  assign cnt_o = cnt_q;

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (cnt_q < cmp_q) && !cnt_wr_i) |=> (cnt_q == $past(cnt_q) + ONE));
  // R8
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_q));
  // R6
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ar_i && (cnt_q >= cmp_q) && !cnt_wr_i) |=> (cnt_q == '0));
  // R7
  preload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_q == $past(wr_data_i)));
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_o
);
  localparam int unsigned PAD_W = CNT_W - 2;

  reg_sel_e         wsel, rsel;
  logic             ctrl_wr, cmp_wr, cnt_wr;
  logic             en, ar, hit, irq_q;
  logic [CNT_W-1:0] cmp_val, cnt_val;

  assign wsel    = reg_sel_e'(wr_sel_i);
  assign rsel    = reg_sel_e'(rd_sel_i);
  assign ctrl_wr = wr_en_i && (wsel == SEL_CTRL);
  assign cmp_wr  = wr_en_i && (wsel == SEL_CMP);
  assign cnt_wr  = wr_en_i && (wsel == SEL_CNT);

  cmp_timer_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .wr_bits_i (wr_data_i[1:0]),
    .hit_i     (hit),
    .en_o      (en),
    .ar_o      (ar)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .ar_i      (ar),
    .cmp_wr_i  (cmp_wr),
    .cnt_wr_i  (cnt_wr),
    .wr_data_i (wr_data_i),
    .hit_o     (hit),
    .cmp_o     (cmp_val),
    .cnt_o     (cnt_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hit;
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (rsel)
      SEL_CTRL: rd_data_o = {{PAD_W{1'b0}}, ar, en};
      SEL_CMP:  rd_data_o = cmp_val;
      SEL_CNT:  rd_data_o = cnt_val;
      default:  rd_data_o = '0;
    endcase
  end

  // R4
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(hit));
  // R8
  no_irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !irq_q);
endmodule

// File: tb/cmp_timer_chan_test.sv
module cmp_timer_chan_test;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_sel = 2'd0;
  logic [W-1:0] rd_data;
  logic         irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench reference state
  logic         m_en, m_ar, m_irq;
  logic [W-1:0] m_cmp, m_cnt;

  cmp_timer_chan #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0: return {{(W-2){1'b0}}, m_ar, m_en};
      2'd1: return m_cmp;
      2'd2: return m_cnt;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check(req, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      check(req, rd_data, exp_read(2'(s)));
    end
  endtask

  // one clock: drive at negedge, update reference at posedge, compare after
  task automatic step(input logic we, input logic [1:0] sel, input logic [W-1:0] d,
                      input string req);
    logic hit;
    wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    hit = m_en && (m_cnt >= m_cmp);
    m_irq = hit;
    if (we && sel == 2'd2)  m_cnt = d;
    else if (hit)           m_cnt = m_ar ? '0 : m_cnt;
    else if (m_en)          m_cnt = m_cnt + 1'b1;
    if (we && sel == 2'd0) begin
      m_en = d[0]; m_ar = d[1];
    end else if (hit && !m_ar) m_en = 1'b0;
    if (we && sel == 2'd1) m_cmp = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_all(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 0; m_ar = 0; m_irq = 0; m_cmp = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 control bit readback, R10 enable at/above compare (cmp=0, cnt=0)
    step(1'b1, 2'd0, 8'h03, "R2");
    idle(3, "R6");
    step(1'b1, 2'd0, 8'hFC, "R2");
    // R3 counting, R4 single pulse, R5 one-shot stop
    step(1'b1, 2'd1, 8'd5, "R9");
    step(1'b1, 2'd0, 8'h01, "R3");
    idle(9, "R5");
    // R6 auto-restart periods
    step(1'b1, 2'd2, 8'd0, "R7");
    step(1'b1, 2'd0, 8'h03, "R6");
    idle(14, "R6");
    // R9 compare lowered mid-period
    step(1'b1, 2'd1, 8'd2, "R9");
    idle(6, "R9");
    // R8 freeze and resume, R7 preload
    step(1'b1, 2'd0, 8'h02, "R8");
    idle(4, "R8");
    step(1'b1, 2'd1, 8'd200, "R9");
    step(1'b1, 2'd2, 8'd196, "R7");
    step(1'b1, 2'd0, 8'h01, "R7");
    idle(7, "R7");
    // R10 preload above compare
    step(1'b1, 2'd2, 8'hFF, "R10");
    step(1'b1, 2'd0, 8'h01, "R10");
    idle(2, "R10");
    // R11 control write colliding with terminal count
    step(1'b1, 2'd1, 8'd3, "R11");
    step(1'b1, 2'd2, 8'd0, "R11");
    step(1'b1, 2'd0, 8'h01, "R11");
    idle(3, "R11");
    step(1'b1, 2'd0, 8'h01, "R11");
    idle(2, "R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 80) step(1'b0, 2'd0, '0, "R4");
      else begin
        logic [1:0]   s;
        logic [W-1:0] d;
        s = 2'($urandom_range(0, 3));
        d = W'($urandom);
        if (s == 2'd1 && r < 90) d = W'($urandom_range(0, 20));
        step(1'b1, s, d, (s == 2'd0) ? "R2" : (s == 2'd1) ? "R9" :
                         (s == 2'd2) ? "R7" : "R3");
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule